// File: doc/BRIEF.md
# Multi-Channel Single-Unit DMA Engine

This block copies data between locations of a 64 KB on-chip window on behalf of software and peripherals. Each of its `NUM_CH` channels holds a source pointer, a destination pointer, a remaining-transfer count and a mode word, all written over a simple write-only register port. A channel becomes pending after one of three events:

- a software start bit written together with its mode word;
- a one-cycle request strobe from a peripheral;
- the completion of one unit on another channel that it is linked to.

Every time a channel is served it moves exactly one 8-bit or 16-bit unit. The engine requests the master bus, reads the unit from the source, then writes it to the destination. It then releases the bus and returns to idle. Only the low 16 address bits are generated, and a fixed parameterised upper half is placed on top of them. When a channel's count runs out, the engine raises a sticky terminal flag and a one-cycle interrupt pulse for that channel, and the channel switches itself off. Bus arbitration and the memory behind the master bus belong to the surrounding system.

Top module: `xfer_dma`

## Requirements
- R1: After reset, `busReq`, `memRd`, `memWr`, `irqPulse` and `tcFlag` are all low.
- R2: The register port selects channel `regAddr[RA_W-1:2]` and field `regAddr[1:0]`. Field 0 is the source pointer, field 1 is the destination pointer, field 2 is the count and field 3 is the mode.
  - Mode bits: bit 0 enable, bit 1 16-bit unit, bit 2 source increment, bit 3 destination increment, bits 5:4 trigger (0 software, 1 peripheral, 2 linked), bit 6 software start, bits 11:8 index of the linked-from channel.
- R3: Each service of a channel follows a fixed sequence of cycles.
  - `busReq` rises one cycle after the channel becomes pending.
  - `memRd` is asserted for one cycle, in the cycle after `busGnt` is seen high. The engine waits as long as the grant is withheld.
  - `memWr` is asserted for one cycle, two cycles after `memRd`.
  - `busReq` drops in the cycle after the write.
- R4: With a 16-bit unit, `memWide` is high and both bytes are moved. With an 8-bit unit, `memWide` is low, only data bits 7:0 carry the unit, and `memWData[15:8]` is zero.
- R5: After each unit, the source and destination pointers either stay unchanged or advance by the unit size (1 or 2), each as selected by its own increment bit.
- R6: A count value of c yields c+1 transfers, so the largest count (255) yields 256 transfers.
- R7: After its last transfer, a channel raises a one-cycle `irqPulse` bit and a `tcFlag` bit, and disables itself.
  - `tcFlag` stays set until that channel's mode word is written.
  - Any later trigger of the disabled channel moves nothing.
- R8: A peripheral strobe `hwReq[i]` starts one unit only on an enabled channel in peripheral trigger mode. A software start bit starts one unit only in software trigger mode.
- R9: A channel in linked mode receives one pending request each time a unit completes on the channel named in its link field.
- R10: When several channels are pending at once, the lowest-numbered channel is served first.
- R11: A software start written with the enable bit clear causes no bus activity.
- R12: `memAddr[31:16]` always equals the `BASE_HI` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | CH_W+2 | Channel index and field select |
| regWrData | input | 16 | Register write data |
| hwReq | input | NUM_CH | Peripheral request strobes, one per channel |
| busGnt | input | 1 | Master bus grant |
| busReq | output | 1 | Master bus request |
| memAddr | output | 32 | Bus address (BASE_HI over 16 generated bits) |
| memRd | output | 1 | Read cycle strobe |
| memWr | output | 1 | Write cycle strobe |
| memWide | output | 1 | Unit size: 1 = 16 bits, 0 = 8 bits |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Read data, valid in the cycle after `memRd` |
| irqPulse | output | NUM_CH | One-cycle terminal interrupt per channel |
| tcFlag | output | NUM_CH | Sticky terminal-count flags |

## Verification
The register write that starts a channel is sampled at clock edge 0. From there the schedule is fixed when the grant is immediate:

| Output | Becomes visible after edge |
|---|---|
| `busReq` | 1 |
| `memRd` | 2 |
| `memWr` | 4 |
| `irqPulse` and `tcFlag`, with `busReq` low again | 5 |

The timing check samples each of these on the falling edge that follows its own rising edge. A further check withholds the grant and confirms that the read waits for it.

Multi-unit scenarios are checked after a fixed settling gap that is longer than one service. Those checks compare the bench memory image with expectations, together with the write-address log that the bench records. Ordering between channels, for priority and for linking, is judged from the order of entries in that log.

// File: rtl/xfer_dma_pkg.sv
package xfer_dma_pkg;

  localparam int WIN_AW = 16;

  // mode word bit positions
  localparam int MB_EN    = 0;
  localparam int MB_WIDE  = 1;
  localparam int MB_SINC  = 2;
  localparam int MB_DINC  = 3;
  localparam int MB_TRGLO = 4;
  localparam int MB_GO    = 6;
  localparam int MB_LNKLO = 8;

  // register field codes
  localparam logic [1:0] FLD_SRC  = 2'd0;
  localparam logic [1:0] FLD_DST  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_MODE = 2'd3;

  // trigger sources
  localparam logic [1:0] TRIG_SW   = 2'd0;
  localparam logic [1:0] TRIG_HW   = 2'd1;
  localparam logic [1:0] TRIG_LINK = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_LAT, ST_WR
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       useSrc;   // drive source pointer on the bus
    logic       capture;  // latch read data
    logic       commit;   // step pointers and count of chSel
    logic [3:0] chSel;
  } dmaStrobes_t;

endpackage

// File: rtl/xfer_dma_regs.sv
module xfer_dma_regs
  import xfer_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W  = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [RA_W-1:0]          regAddr,
  input  logic [15:0]              regWrData,
  input  dmaStrobes_t              stb,
  input  logic [15:0]              memRData,
  output logic [NUM_CH-1:0]        chEn,
  output logic [NUM_CH-1:0]        swGo,
  output logic [NUM_CH-1:0]        modeWr,
  output logic [NUM_CH-1:0][1:0]   trigSel,
  output logic [NUM_CH-1:0][3:0]   linkSrc,
  output logic                     selLast,
  output logic                     selWide,
  output logic [WIN_AW-1:0]        busAddrLo,
  output logic [15:0]              wrData
);

  logic [WIN_AW-1:0] srcQ [NUM_CH];
  logic [WIN_AW-1:0] dstQ [NUM_CH];
  logic [CNT_W-1:0]  cntQ [NUM_CH];
  logic [NUM_CH-1:0] wideQ, sIncQ, dIncQ;
  logic [15:0]       holdQ;
  logic [CH_W-1:0]   sel;
  logic [1:0]        field;
  logic              selUnused;

  assign sel       = stb.chSel[CH_W-1:0];
  assign selUnused = ^stb.chSel;
  assign field     = regAddr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit, mine;
    logic [WIN_AW-1:0] step;

    assign hit       = regWrEn && (regAddr[RA_W-1:2] == CH_W'(g));
    assign mine      = stb.commit && (sel == CH_W'(g));
    assign step      = wideQ[g] ? WIN_AW'(2) : WIN_AW'(1);
    assign modeWr[g] = hit && (field == FLD_MODE);
    assign swGo[g]   = modeWr[g] && regWrData[MB_EN] && regWrData[MB_GO]
                       && (regWrData[MB_TRGLO+1:MB_TRGLO] == TRIG_SW);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcQ[g]    <= '0;
        dstQ[g]    <= '0;
        cntQ[g]    <= '0;
        chEn[g]    <= 1'b0;
        wideQ[g]   <= 1'b0;
        sIncQ[g]   <= 1'b0;
        dIncQ[g]   <= 1'b0;
        trigSel[g] <= TRIG_SW;
        linkSrc[g] <= '0;
      end else begin
        if (mine) begin
          if (sIncQ[g]) srcQ[g] <= srcQ[g] + step;
          if (dIncQ[g]) dstQ[g] <= dstQ[g] + step;
          if (cntQ[g] == '0) chEn[g] <= 1'b0;
          else               cntQ[g] <= cntQ[g] - 1'b1;
        end
        if (hit) begin
          unique case (field)
            FLD_SRC: srcQ[g] <= regWrData[WIN_AW-1:0];
            FLD_DST: dstQ[g] <= regWrData[WIN_AW-1:0];
            FLD_CNT: cntQ[g] <= regWrData[CNT_W-1:0];
            default: begin
              chEn[g]    <= regWrData[MB_EN];
              wideQ[g]   <= regWrData[MB_WIDE];
              sIncQ[g]   <= regWrData[MB_SINC];
              dIncQ[g]   <= regWrData[MB_DINC];
              trigSel[g] <= regWrData[MB_TRGLO+1:MB_TRGLO];
              linkSrc[g] <= regWrData[MB_LNKLO+3:MB_LNKLO];
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdQ <= '0;
    else if (stb.capture) holdQ <= memRData;
  end

  assign selLast   = (cntQ[sel] == '0);
  assign selWide   = wideQ[sel];
  assign busAddrLo = stb.useSrc ? srcQ[sel] : dstQ[sel];
  assign wrData    = selWide ? holdQ : {8'h00, holdQ[7:0]};

endmodule

// File: rtl/xfer_dma_ctrl.sv
module xfer_dma_ctrl
  import xfer_dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      chEn,
  input  logic [NUM_CH-1:0]      swGo,
  input  logic [NUM_CH-1:0]      modeWr,
  input  logic [NUM_CH-1:0][1:0] trigSel,
  input  logic [NUM_CH-1:0][3:0] linkSrc,
  input  logic [NUM_CH-1:0]      hwReq,
  input  logic                   selLast,
  input  logic                   busGnt,
  output dmaStrobes_t            stb,
  output logic                   busReq,
  output logic                   memRd,
  output logic                   memWr,
  output logic [NUM_CH-1:0]      irqPulse,
  output logic [NUM_CH-1:0]      tcFlag
);

  dmaState_t         state;
  logic [NUM_CH-1:0] pendQ, setV, clrV, ready, doneV;
  logic [CH_W-1:0]   curCh, pick;
  logic              anyReady;

  always_comb begin
    for (int j = 0; j < NUM_CH; j++) begin
      setV[j] = swGo[j]
             || (chEn[j] && trigSel[j] == TRIG_HW && hwReq[j])
             || (chEn[j] && trigSel[j] == TRIG_LINK && state == ST_WR
                 && linkSrc[j] == 4'(curCh));
    end
  end

  assign clrV     = (state == ST_WR) ? (NUM_CH'(1) << curCh) : '0;
  assign doneV    = selLast ? clrV : '0;
  assign ready    = pendQ & chEn;
  assign anyReady = |ready;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ready[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curCh    <= '0;
      pendQ    <= '0;
      irqPulse <= '0;
      tcFlag   <= '0;
    end else begin
      pendQ    <= (pendQ & ~clrV & chEn) | setV;
      irqPulse <= doneV;
      tcFlag   <= (tcFlag & ~modeWr) | doneV;
      unique case (state)
        ST_IDLE: if (anyReady) begin
          curCh <= pick;
          state <= ST_REQ;
        end
        ST_REQ:  if (busGnt) state <= ST_RD;
        ST_RD:   state <= ST_LAT;
        ST_LAT:  state <= ST_WR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busReq      = (state != ST_IDLE);
  assign memRd       = (state == ST_RD);
  assign memWr       = (state == ST_WR);
  assign stb.useSrc  = (state == ST_RD);
  assign stb.capture = (state == ST_LAT);
  assign stb.commit  = (state == ST_WR);
  assign stb.chSel   = 4'(curCh);

  // R3: a read and a write never share a cycle
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R3: every write comes two cycles after its read
  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd, 2));
  // R3: bus released only right after a write
  p_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(memWr));
  // R7: at most one terminal interrupt at a time
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqPulse));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R7: interrupting channel is already switched off
    p_irq_disables_r7: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[k] |-> !chEn[k]);
    // R7: flag only cleared by a mode write
    p_tc_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (tcFlag[k] && !modeWr[k]) |=> tcFlag[k]);
  end

endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import xfer_dma_pkg::*;
#(
  parameter int          NUM_CH  = 4,
  parameter int          CNT_W   = 8,
  parameter logic [15:0] BASE_HI = 16'h0080,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [15:0]       regWrData,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic              busGnt,
  output logic              busReq,
  output logic [31:0]       memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              memWide,
  output logic [15:0]       memWData,
  input  logic [15:0]       memRData,
  output logic [NUM_CH-1:0] irqPulse,
  output logic [NUM_CH-1:0] tcFlag
);

  dmaStrobes_t              stb;
  logic [NUM_CH-1:0]        chEn, swGo, modeWr;
  logic [NUM_CH-1:0][1:0]   trigSel;
  logic [NUM_CH-1:0][3:0]   linkSrc;
  logic                     selLast;
  logic [WIN_AW-1:0]        busAddrLo;

  xfer_dma_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb), .memRData(memRData),
    .chEn(chEn), .swGo(swGo), .modeWr(modeWr), .trigSel(trigSel),
    .linkSrc(linkSrc), .selLast(selLast), .selWide(memWide),
    .busAddrLo(busAddrLo), .wrData(memWData)
  );

  xfer_dma_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .chEn(chEn), .swGo(swGo), .modeWr(modeWr),
    .trigSel(trigSel), .linkSrc(linkSrc), .hwReq(hwReq), .selLast(selLast),
    .busGnt(busGnt), .stb(stb), .busReq(busReq), .memRd(memRd),
    .memWr(memWr), .irqPulse(irqPulse), .tcFlag(tcFlag)
  );

  assign memAddr = {BASE_HI, busAddrLo};

endmodule

// File: tb/test_xfer_dma.sv
module test_xfer_dma;

  localparam int NUM_CH = 4;
  localparam logic [15:0] BASE = 16'h0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [3:0]  hwReq = '0;
  logic        busGnt, busReq, memRd, memWr, memWide;
  logic        gntAllow = 1'b1;
  logic [31:0] memAddr;
  logic [15:0] memWData;
  logic [15:0] memRData = '0;
  logic [3:0]  irqPulse, tcFlag;

  logic [7:0]  mem [0:1023];
  logic [15:0] wrLog [0:1023];
  int          wrCount = 0;
  int          irqCount = 0;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;
  assign busGnt = busReq & gntAllow;

  xfer_dma #(.NUM_CH(NUM_CH), .BASE_HI(BASE)) i_xfer_dma (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hwReq(hwReq), .busGnt(busGnt), .busReq(busReq),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWide(memWide),
    .memWData(memWData), .memRData(memRData), .irqPulse(irqPulse),
    .tcFlag(tcFlag)
  );

  // bus memory model and write logger
  always @(posedge clk) begin
    if (memRd)
      memRData <= memWide ? {mem[memAddr[9:0] + 10'd1], mem[memAddr[9:0]]}
                          : {8'h00, mem[memAddr[9:0]]};
    if (memWr) begin
      mem[memAddr[9:0]] <= memWData[7:0];
      if (memWide) mem[memAddr[9:0] + 10'd1] <= memWData[15:8];
      wrLog[wrCount % 1024] <= memAddr[15:0];
      wrCount <= wrCount + 1;
    end
    if (irqPulse != '0) irqCount <= irqCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit en, input bit wide, input bit sInc,
      input bit dInc, input logic [1:0] trig, input bit go, input logic [3:0] lnk);
    return {4'h0, lnk, 1'b0, go, trig, dInc, sInc, wide, en};
  endfunction

  task automatic regWr(input int ch, input int fld, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = {ch[1:0], fld[1:0]}; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                       input logic [7:0] c);
    regWr(ch, 0, s); regWr(ch, 1, d); regWr(ch, 2, {8'h00, c});
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); hwReq = m;
    @(negedge clk); hwReq = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busReq", busReq, 0);
    chk("R1 rd/wr", {memRd, memWr}, 0);
    chk("R1 tcFlag", tcFlag, 0);
    chk("R1 irq", irqPulse, 0);
  endtask

  task automatic t_timing;
    mem[10'h100] = 8'hA5;
    setup(0, 16'h0100, 16'h0200, 8'd0);
    regWr(0, 3, mk(1, 0, 0, 0, 2'd0, 1, 4'd0)); // edge 0 sampled
    chk("R3 no req at edge0", busReq, 0);
    @(negedge clk);
    chk("R3 req edge1", {busReq, memRd}, 2'b10);
    @(negedge clk);
    chk("R3 read edge2", memRd, 1);
    chk("R2 src addr R12", memAddr, {BASE, 16'h0100});
    @(negedge clk);
    chk("R3 gap edge3", {memRd, memWr}, 0);
    @(negedge clk);
    chk("R3 write edge4", memWr, 1);
    chk("R2 dst addr", memAddr[15:0], 16'h0200);
    chk("R4 narrow data", memWData, 16'h00A5);
    chk("R4 narrow size", memWide, 0);
    chk("R12 base", memAddr[31:16], BASE);
    @(negedge clk);
    chk("R3 release edge5", busReq, 0);
    chk("R7 irq pulse", irqPulse, 4'b0001);
    chk("R7 tc set", tcFlag, 4'b0001);
    chk("R3 data moved", mem[10'h200], 8'hA5);
    @(negedge clk);
    chk("R7 irq one cycle", irqPulse, 0);
  endtask

  task automatic t_grant;
    setup(0, 16'h0100, 16'h0202, 8'd0);
    gntAllow = 1'b0;
    regWr(0, 3, mk(1, 0, 0, 0, 2'd0, 1, 4'd0));
    chk("R7 tc cleared by mode write", tcFlag[0], 0);
    idle(5);
    chk("R3 waits for grant", {busReq, memRd}, 2'b10);
    gntAllow = 1'b1;
    @(negedge clk);
    chk("R3 read after grant", memRd, 1);
    idle(6);
    chk("R3 moved after grant", mem[10'h202], 8'hA5);
  endtask

  task automatic t_wide;
    int base;
    for (int i = 0; i < 6; i++) mem[10'h300 + i] = 8'(8'h11 * (i + 1));
    setup(1, 16'h0300, 16'h0340, 8'd2);
    base = wrCount;
    for (int n = 0; n < 3; n++) begin
      regWr(1, 3, mk(1, 1, 1, 1, 2'd0, 1, 4'd0));
      idle(8);
    end
    chk("R6 three units", wrCount - base, 3);
    for (int i = 0; i < 6; i++) chk("R4 wide bytes", mem[10'h340 + i], 8'(8'h11 * (i + 1)));
    chk("R5 dst +2 a", wrLog[base + 1], 16'h0342);
    chk("R5 dst +2 b", wrLog[base + 2], 16'h0344);
    chk("R7 tc ch1", tcFlag[1], 1);
  endtask

  task automatic t_narrowFixed;
    int base, irq0;
    mem[10'h380] = 8'hA1; mem[10'h381] = 8'hB2; mem[10'h382] = 8'hC3; mem[10'h383] = 8'hD4;
    mem[10'h3C1] = 8'h77;
    setup(2, 16'h0380, 16'h03C0, 8'd3);
    base = wrCount; irq0 = irqCount;
    for (int n = 0; n < 4; n++) begin
      regWr(2, 3, mk(1, 0, 1, 0, 2'd0, 1, 4'd0));
      idle(8);
    end
    chk("R6 four units", wrCount - base, 4);
    chk("R5 fixed dst last byte", mem[10'h3C0], 8'hD4);
    chk("R4 upper lane untouched", mem[10'h3C1], 8'h77);
    chk("R5 fixed dst addr", wrLog[base + 3], 16'h03C0);
    chk("R7 one irq", irqCount - irq0, 1);
  endtask

  task automatic t_hw;
    int base;
    mem[10'h140] = 8'h3C; mem[10'h141] = 8'h4D;
    setup(3, 16'h0140, 16'h0150, 8'd1);
    base = wrCount;
    regWr(3, 3, mk(1, 0, 1, 1, 2'd1, 1, 4'd0));
    idle(8);
    chk("R8 sw go ignored in hw mode", wrCount - base, 0);
    pulse(4'b0001);
    idle(8);
    chk("R8 strobe to other channel ignored", wrCount - base, 0);
    pulse(4'b1000);
    idle(8);
    chk("R8 strobe moves one unit", wrCount - base, 1);
    chk("R8 data", mem[10'h150], 8'h3C);
    pulse(4'b1000);
    idle(8);
    chk("R7 tc after last", tcFlag[3], 1);
    pulse(4'b1000);
    idle(8);
    chk("R7 disabled ignores trigger", wrCount - base, 2);
    chk("R7 tc sticky", tcFlag[3], 1);
    regWr(3, 3, mk(0, 0, 0, 0, 2'd1, 0, 4'd0));
    @(negedge clk);
    chk("R7 tc cleared", tcFlag[3], 0);
  endtask

  task automatic t_disabled;
    int base;
    base = wrCount;
    regWr(1, 3, mk(0, 0, 0, 0, 2'd0, 1, 4'd0));
    idle(20);
    chk("R11 disabled start", wrCount - base, 0);
    chk("R11 no bus", busReq, 0);
  endtask

  task automatic t_link;
    int base;
    mem[10'h100] = 8'h5A;
    setup(0, 16'h0100, 16'h0120, 8'd0);
    setup(2, 16'h0120, 16'h0130, 8'd0);
    regWr(2, 3, mk(1, 0, 0, 0, 2'd2, 0, 4'd0));
    base = wrCount;
    regWr(0, 3, mk(1, 0, 0, 0, 2'd0, 1, 4'd0));
    idle(16);
    chk("R9 two units", wrCount - base, 2);
    chk("R9 order first", wrLog[base], 16'h0120);
    chk("R9 order second", wrLog[base + 1], 16'h0130);
    chk("R9 linked copy", mem[10'h130], 8'h5A);
  endtask

  task automatic t_priority;
    int base;
    setup(1, 16'h0100, 16'h03E8, 8'd0);
    setup(3, 16'h0100, 16'h03E0, 8'd0);
    regWr(1, 3, mk(1, 0, 0, 0, 2'd1, 0, 4'd0));
    regWr(3, 3, mk(1, 0, 0, 0, 2'd1, 0, 4'd0));
    base = wrCount;
    pulse(4'b1010);
    idle(16);
    chk("R10 both served", wrCount - base, 2);
    chk("R10 low index first", wrLog[base], 16'h03E8);
    chk("R10 high index second", wrLog[base + 1], 16'h03E0);
  endtask

  task automatic t_count256;
    int base;
    for (int i = 0; i < 260; i++) mem[10'h200 + i] = 8'h00;
    setup(0, 16'h0100, 16'h0200, 8'd255);
    regWr(0, 3, mk(1, 0, 0, 1, 2'd1, 0, 4'd0));
    base = wrCount;
    for (int n = 0; n < 256; n++) begin
      pulse(4'b0001);
      idle(6);
    end
    chk("R6 256 transfers", wrCount - base, 256);
    chk("R6 tc at 256", tcFlag[0], 1);
    chk("R5 last dst", wrLog[(base + 255) % 1024], 16'h02FF);
    pulse(4'b0001);
    idle(8);
    chk("R6 no 257th", wrCount - base, 256);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_timing();
    t_grant();
    t_wide();
    t_narrowFixed();
    t_hw();
    t_disabled();
    t_link();
    t_priority();
    t_count256();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule